// File: doc/BRIEF.md
# Triangle-Ramp Pulse Height Digitizer

This block measures the height of a slow analog level with one comparator bit and an external DAC. It sweeps an 8-bit reference code up and down without stopping and drives that code out to the DAC. The comparator reports whether the analog input lies at or above the DAC output. Each time the synchronized comparator bit changes, in either direction, the block takes the reference code present at that moment as the pulse height. The code does not restart at zero for each conversion, so a crossing on the rising slope and a crossing on the falling slope both give a result directly.

Each result comes out with a one-clock valid strobe. The result is also sorted into one of eight display ranges and shown as a seven-segment digit, which holds until the next result. The code advances one step every `STEP_CLKS` clocks (50 by default) so that the DAC output has time to settle.

Two state machines control the block. The sweeper has two states. In `SWP_RISE` the code counts up, and the move `rise_to_fall` happens on the step taken at the top code. In `SWP_FALL` the code counts down, and the move `fall_to_rise` happens on the step taken at code 1. The capture machine also has two states. It starts in `CAP_PRIME` while the synchronizer fills, takes the move `prime_done`, and then stays in `CAP_WATCH`, where every detected toggle is captured.

Top module: `tri_height_digitizer`

## Requirements
- R1: While reset is held and right after it is released, `ref_code` is 0, `height_vld` is 0, `height` is 0, `bin_digit` is 0 and `seg_out` is 0 (blank).
- R2: `ref_code` changes only once every `STEP_CLKS` clocks, and each change is by exactly one. The first change happens on the `STEP_CLKS`-th clock edge after reset is released.
- R3: After reset the code counts upward from 0. The step after code 255 gives 254, so 255 is never repeated.
- R4: On the way down, the step after code 1 gives 2. After the first step, code 0 never appears again.
- R5: `comp_in` passes through a two-flop synchronizer. No capture comes from the comparator level present at reset release.
- R6: When the synchronized comparator changes from 1 to 0, `height` takes the value of `ref_code` at the edge where the change is seen, three clock edges after `comp_in` changes. With an ideal comparator (input ≥ code) at level L on the rising slope, the result is L+1.
- R7: A change of the synchronized comparator from 0 to 1 also causes a capture. On the falling slope this gives L.
- R8: Each comparator toggle gives exactly one `height_vld` pulse of one clock. A comparator that never changes gives no pulse.
- R9: `bin_digit` is 1 for heights 0–32, 2 for 33–64, 3 for 65–96, 4 for 97–128, 5 for 129–160, 6 for 161–192, 7 for 193–224 and 8 for 225–255.
- R10: `seg_out` is active-high with bit 0 = a through bit 6 = g. The patterns are 1=0x06, 2=0x5B, 3=0x4F, 4=0x66, 5=0x6D, 6=0x7D, 7=0x07, 8=0x7F.
- R11: `height`, `bin_digit` and `seg_out` keep their values until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| comp_in | input | 1 | Asynchronous comparator result |
| ref_code | output | CODE_W | Triangle reference code to the DAC |
| height | output | CODE_W | Last captured height |
| height_vld | output | 1 | One-clock strobe for a new height |
| bin_digit | output | 4 | Display range 1–8, 0 before any capture |
| seg_out | output | 7 | Active-high segments, bit 0 = a |

## Verification
The two turning points are the hardest cases to reach. A crossing near the top of the sweep needs a level close to 255, and a crossing near the bottom needs a level close to 1. Reaching either one takes hundreds of paced steps. The bench runs the block with a short step period so that every trial covers a full rise, a full fall and the start of the next rise. It follows an ideal comparator and mixes random levels with directed levels at 0, 1, 254, 255 and the bin edges. Level 0 checks the single capture that comes just after start-up, and level 255 checks that no capture occurs at all.

// File: rtl/tri_pkg.sv
package tri_pkg;

    typedef enum logic {
        SWP_RISE,
        SWP_FALL
    } sweep_e;

    typedef enum logic {
        CAP_PRIME,
        CAP_WATCH
    } cap_e;

    // active-high segment pattern, bit0 = a .. bit6 = g
    function automatic logic [6:0] seg_of(input logic [3:0] digit);
        logic [6:0] s;
        unique case (digit)
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            default: s = 7'h00;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tri_step_pacer.sv
module tri_step_pacer #(
    parameter int STEP_CLKS = 50
) (
    input  logic clk,
    input  logic rst_n,
    output logic step_tick
);
    localparam int CW = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEP_CLKS - 1);

    logic [CW-1:0] cnt_q;

    assign step_tick = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (step_tick) cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    generate
        if (STEP_CLKS > 1) begin : g_spaced
            assert_tick_spaced_R2: assert property (@(posedge clk) disable iff (!rst_n)
                step_tick |=> !step_tick);
        end
    endgenerate

endmodule

// File: rtl/tri_sweeper.sv
module tri_sweeper
    import tri_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_tick,
    output logic [CODE_W-1:0] code
);
    localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] ONE = CODE_W'(1);

    sweep_e              state_q, state_d;
    logic [CODE_W-1:0]   code_q,  code_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SWP_RISE;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
        end
    end

    // next state and code
    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        if (step_tick) begin
            unique case (state_q)
                SWP_RISE: begin
                    if (code_q == TOP) begin
                        state_d = SWP_FALL;          // rise_to_fall
                        code_d  = code_q - 1'b1;
                    end else begin
                        code_d  = code_q + 1'b1;
                    end
                end
                SWP_FALL: begin
                    if (code_q == ONE) begin
                        state_d = SWP_RISE;          // fall_to_rise
                        code_d  = code_q + 1'b1;
                    end else begin
                        code_d  = code_q - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign code = code_q;

    assert_hold_between_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step_tick |=> $stable(code_q));
    assert_unit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step_tick |=> ((int'(code_q) - int'($past(code_q)) == 1) ||
                       (int'($past(code_q)) - int'(code_q) == 1)));
    assert_top_turns_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_tick && code_q == TOP) |=> (code_q == TOP - 1'b1));
    assert_no_zero_falling_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SWP_FALL) |-> (code_q != '0));

endmodule

// File: rtl/tri_toggle_capture.sv
module tri_toggle_capture
    import tri_pkg::*;
#(
    parameter int CODE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              comp_in,
    input  logic [CODE_W-1:0] code,
    output logic              fire,
    output logic [CODE_W-1:0] height,
    output logic              height_vld
);
    localparam int PW = $clog2(SYNC_STAGES + 1) + 1;
    localparam logic [PW-1:0] PRIME_LAST = PW'(SYNC_STAGES);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   toggle;
    cap_e                   state_q, state_d;
    logic [PW-1:0]          prime_q;
    logic [CODE_W-1:0]      height_q;
    logic                   vld_q;

    // synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= comp_in;
    end
    generate
        for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[i] <= 1'b0;
                else        sync_q[i] <= sync_q[i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign toggle = sync_q[SYNC_STAGES-1] ^ prev_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CAP_PRIME;
            prime_q <= '0;
        end else begin
            state_q <= state_d;
            prime_q <= (state_q == CAP_PRIME) ? prime_q + 1'b1 : prime_q;
        end
    end

    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
            CAP_PRIME: if (prime_q == PRIME_LAST) state_d = CAP_WATCH;   // prime_done
            CAP_WATCH: fire = toggle;
            default: ;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            height_q <= '0;
            vld_q    <= 1'b0;
        end else begin
            vld_q <= fire;
            if (fire) height_q <= code;
        end
    end

    assign height     = height_q;
    assign height_vld = vld_q;

    assert_no_capture_while_priming_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAP_PRIME) |=> !vld_q);
    assert_height_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(height_q));
    assert_strobe_from_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> $past(sync_q[SYNC_STAGES-1]) != $past(prev_q));

endmodule

// File: rtl/tri_bin_display.sv
module tri_bin_display
    import tri_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [CODE_W-1:0] code,
    output logic [3:0]        bin_digit,
    output logic [6:0]        seg_out
);
    localparam int SHIFT = CODE_W - 3;

    logic [CODE_W-1:0] less_one;
    logic [3:0]        digit_d, digit_q;
    logic [6:0]        seg_q;

    assign less_one = code - 1'b1;

    always_comb begin
        if (code == '0) digit_d = 4'd1;
        else            digit_d = 4'(less_one >> SHIFT) + 4'd1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            digit_q <= '0;
            seg_q   <= '0;
        end else if (fire) begin
            digit_q <= digit_d;
            seg_q   <= seg_of(digit_d);
        end
    end

    assign bin_digit = digit_q;
    assign seg_out   = seg_q;

    assert_digit_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (digit_q >= 4'd1 && digit_q <= 4'd8));
    assert_seg_lit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (seg_q != 7'h00));
    assert_display_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> ($stable(digit_q) && $stable(seg_q)));

endmodule

// File: rtl/tri_height_digitizer.sv
module tri_height_digitizer #(
    parameter int CODE_W    = 8,
    parameter int STEP_CLKS = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              comp_in,
    output logic [CODE_W-1:0] ref_code,
    output logic [CODE_W-1:0] height,
    output logic              height_vld,
    output logic [3:0]        bin_digit,
    output logic [6:0]        seg_out
);
    localparam int SYNC_STAGES = 2;

    logic step_tick;
    logic fire;

    tri_step_pacer #(.STEP_CLKS(STEP_CLKS)) u_pacer (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_tick (step_tick)
    );

    tri_sweeper #(.CODE_W(CODE_W)) u_sweep (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_tick (step_tick),
        .code      (ref_code)
    );

    tri_toggle_capture #(.CODE_W(CODE_W), .SYNC_STAGES(SYNC_STAGES)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .comp_in    (comp_in),
        .code       (ref_code),
        .fire       (fire),
        .height     (height),
        .height_vld (height_vld)
    );

    tri_bin_display #(.CODE_W(CODE_W)) u_disp (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .code      (ref_code),
        .bin_digit (bin_digit),
        .seg_out   (seg_out)
    );

    assert_strobe_updates_display_R9: assert property (@(posedge clk) disable iff (!rst_n)
        height_vld |-> (bin_digit != 4'd0));

endmodule

// File: tb/sim_tri_height_digitizer.sv
module sim_tri_height_digitizer;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int STEP       = 6;
    localparam int TICKS      = 530;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         comp_in = 1'b1;
    logic [W-1:0] ref_code, height;
    logic         height_vld;
    logic [3:0]   bin_digit;
    logic [6:0]   seg_out;

    int checks = 0;
    int fails  = 0;

    tri_height_digitizer #(.CODE_W(W), .STEP_CLKS(STEP)) u0 (
        .clk(clk), .rst_n(rst_n), .comp_in(comp_in), .ref_code(ref_code),
        .height(height), .height_vld(height_vld), .bin_digit(bin_digit), .seg_out(seg_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int model_code(int ticks);
        int p;
        if (ticks <= 255) return ticks;
        p = (ticks - 255) % 508;
        if (p <= 254) return 255 - p;
        return p - 253;
    endfunction

    function automatic int model_digit(int h);
        if (h <= 32)  return 1;
        if (h <= 64)  return 2;
        if (h <= 96)  return 3;
        if (h <= 128) return 4;
        if (h <= 160) return 5;
        if (h <= 192) return 6;
        if (h <= 224) return 7;
        return 8;
    endfunction

    function automatic int model_seg(int d);
        case (d)
            1: return 'h06;  2: return 'h5B;  3: return 'h4F;  4: return 'h66;
            5: return 'h6D;  6: return 'h7D;  7: return 'h07;  8: return 'h7F;
            default: return 0;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic run_level(input int lvl);
        int edges, exp_h, exp_d, caps, toggles, code_bad, hold_bad, first_bad, first_exp;
        string rq;
        edges = 0; exp_h = 0; exp_d = 0; caps = 0; toggles = 0;
        code_bad = 0; hold_bad = 0; first_bad = 0; first_exp = 0;
        @(negedge clk);
        rst_n   = 1'b0;
        comp_in = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(ref_code == 0 && height_vld == 0 && height == 0, "R1 reset outputs", ref_code, 0);
        check(bin_digit == 0 && seg_out == 0, "R1 reset display", seg_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ref_code == 0 && bin_digit == 0, "R1 after release", ref_code, 0);
        edges = 1;
        for (int c = 1; c < TICKS * STEP + 4; c++) begin
            if (ref_code != W'(model_code(edges / STEP))) begin
                if (code_bad == 0) begin first_bad = ref_code; first_exp = model_code(edges / STEP); end
                code_bad++;
            end
            if (height_vld) begin
                caps++;
                // R6 falling comp -> L+1; R7 rising comp -> L
                rq = comp_in ? "R7 capture on rise of comparator" : "R6 capture on fall of comparator";
                check(int'(height) == (comp_in ? lvl : lvl + 1), rq, height, comp_in ? lvl : lvl + 1);
                exp_h = comp_in ? lvl : lvl + 1;
                exp_d = model_digit(exp_h);
                check(int'(bin_digit) == exp_d, "R9 bin digit", bin_digit, exp_d);
                check(int'(seg_out) == model_seg(exp_d), "R10 segments", seg_out, model_seg(exp_d));
            end else begin
                if (int'(height) != exp_h || int'(bin_digit) != exp_d ||
                    int'(seg_out) != model_seg(exp_d)) hold_bad++;
            end
            if (comp_in != (lvl >= int'(ref_code))) toggles++;
            comp_in = (lvl >= int'(ref_code));
            @(posedge clk);
            edges++;
            @(negedge clk);
        end
        check(code_bad == 0, "R2 R3 R4 reference code sequence", first_bad, first_exp);
        check(hold_bad == 0, "R11 outputs hold between captures", hold_bad, 0);
        check(caps == toggles, "R8 one strobe per toggle", caps, toggles);
        if (lvl == 255) check(caps == 0, "R8 steady comparator gives no capture", caps, 0);
        if (lvl == 0)   check(caps == 1, "R5 no capture from start-up level", caps, 1);
    endtask

    initial begin
        void'($urandom(32'h5A17));
        run_level(0);
        run_level(255);
        run_level(1);
        run_level(254);
        run_level(32);
        run_level(33);
        run_level(128);
        run_level(224);
        run_level(225);
        for (int k = 0; k < 7; k++) run_level(int'($urandom_range(2, 253)));
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule